// File: doc/BRIEF.md
# Packed Calendar Clock Counter

This block keeps calendar time of day in one 32-bit word of binary fields (second, minute, hour, weekday, day of month, month) and keeps the year in a second word as BCD digits. A one-cycle `tick` strobe, normally once per second, advances the count. Each carry ripples upward through the fields, using the true length of the current month and the leap-year rule for February. When December rolls over, the BCD year is incremented with decimal carry.

New time and year values are written through two load ports. A write is held in a staging register and takes effect at the next tick, in place of that tick's advance. This lets software write both words and have them change in the same cycle. Two match registers hold an alarm time and year. The `alarm` output gives a single-cycle pulse when the running count first equals both match words. Every field takes part in that compare, including the weekday.

Top module: `cal_clock_top`

## Requirements
- R1: After reset the time word reads 0x0212_0000 (Sunday, 1 January, 00:00:00), the year reads 16'h2000, and `alarm` is low.
- R2: Time word layout: bits 5:0 second (0-59), 11:6 minute (0-59), 16:12 hour (0-23), 19:17 weekday (1-7, 1 = Sunday), 24:20 day of month (1-31), 28:25 month (1-12, 1 = January), bits 31:29 zero. Year word: bits 7:0 hold the low two BCD digits and bits 15:8 hold the century as two BCD digits.
- R3: The time and year change only in a cycle with `tick` high. A tick adds one second. Second 59 wraps to 0 and carries into the minute. Minute 59 wraps to 0 and carries into the hour. Hour 23 wraps to 0 and carries into the day.
- R4: On each day carry the weekday goes from 7 to 1 and otherwise increments by one.
- R5: On a day carry, the day of month wraps to 1 and the month increments once the day reaches the month's length. That length is 30 for April, June, September and November, and 31 for the other months except February.
- R6: February has 29 days when the year is divisible by 4, except for century years not divisible by 400. Otherwise it has 28 days.
- R7: A carry out of month 12 sets the month to 1 and increments the BCD year with decimal carry. For example, 2099 becomes 2100 and 9999 becomes 0000.
- R8: A load write is staged and has no visible effect until the next tick. That tick installs the staged word instead of advancing. Time and year writes staged before the same tick appear together in one cycle.
- R9: Match writes take effect at once. `alarm` pulses high for exactly one cycle, one clock after the time and year registers first equal the match words.
- R10: The weekday field takes part in the compare. A count that equals the match in every field except the weekday raises no alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle advance strobe |
| time_wr | input | 1 | Stage a new time word |
| time_wdata | input | 32 | Time word to stage |
| year_wr | input | 1 | Stage a new year word |
| year_wdata | input | 16 | BCD year to stage |
| mtime_wr | input | 1 | Write the alarm time word |
| mtime_wdata | input | 32 | Alarm time word |
| myear_wr | input | 1 | Write the alarm year word |
| myear_wdata | input | 16 | Alarm BCD year |
| time_q | output | 32 | Current time word |
| year_q | output | 16 | Current BCD year |
| alarm | output | 1 | One-cycle alarm pulse |

## Verification
The count and the year change on the clock edge that samples `tick`, so the bench drives `tick` for one cycle starting at a falling edge and reads `time_q` and `year_q` at the next falling edge. A staged load appears on that same edge, and the bench also checks the outputs over several idle cycles between the write and the tick. `alarm` is due one edge after the match becomes true, so the bench checks it one falling edge after the advancing tick and checks again one cycle later that it has dropped.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;

  typedef struct packed {
    logic [2:0] pad;
    logic [3:0] mon;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_time_t;

  localparam logic [5:0] SEC_LAST  = 6'd59;
  localparam logic [5:0] MIN_LAST  = 6'd59;
  localparam logic [4:0] HOUR_LAST = 5'd23;
  localparam logic [2:0] WDAY_LAST = 3'd7;
  localparam logic [3:0] MON_LAST  = 4'd12;

  // value mod 4 of a two-digit BCD number: 10 mod 4 == 2
  function automatic logic [1:0] bcd2_mod4(input logic [7:0] b);
    return 2'({b[4], 1'b0} + b[1:0]);
  endfunction

endpackage

// File: rtl/cal_bcd_inc.sv
`timescale 1ns/1ps
module cal_bcd_inc #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] d,
  output logic [4*DIGITS-1:0] q
);
  logic [DIGITS:0] cy;
  assign cy[0] = 1'b1;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    logic [3:0] cur;
    logic       top;
    assign cur       = d[4*i +: 4];
    assign top       = (cur >= 4'd9);
    assign cy[i+1]   = cy[i] & top;
    assign q[4*i +: 4] = !cy[i] ? cur : (top ? 4'd0 : cur + 4'd1);
  end
endmodule

// File: rtl/cal_month_len.sv
`timescale 1ns/1ps
module cal_month_len
  import cal_pkg::*;
#(
  parameter int YW = 16
) (
  input  logic [3:0]    mon,
  input  logic [YW-1:0] year,
  output logic [4:0]    days
);
  logic low_zero;
  logic leap;

  assign low_zero = (year[7:0] == 8'h00);
  assign leap     = low_zero ? (bcd2_mod4(year[15:8]) == 2'd0)
                             : (bcd2_mod4(year[7:0])  == 2'd0);

  always_comb begin
    case (mon)
      4'd2:                       days = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:    days = 5'd30;
      default:                    days = 5'd31;
    endcase
  end
endmodule

// File: rtl/cal_advance.sv
`timescale 1ns/1ps
module cal_advance
  import cal_pkg::*;
(
  input  cal_time_t  cur,
  input  logic [4:0] days,
  output cal_time_t  nxt,
  output logic       year_cy
);
  logic sec_w, min_w, hour_w, mday_w, mon_w;

  assign sec_w  = (cur.sec  >= SEC_LAST);
  assign min_w  = (cur.min  >= MIN_LAST);
  assign hour_w = (cur.hour >= HOUR_LAST);
  assign mday_w = (cur.mday >= days);
  assign mon_w  = (cur.mon  >= MON_LAST);

  always_comb begin
    nxt     = cur;
    nxt.pad = 3'd0;
    year_cy = 1'b0;
    nxt.sec = sec_w ? 6'd0 : cur.sec + 6'd1;
    if (sec_w) begin
      nxt.min = min_w ? 6'd0 : cur.min + 6'd1;
      if (min_w) begin
        nxt.hour = hour_w ? 5'd0 : cur.hour + 5'd1;
        if (hour_w) begin
          nxt.wday = (cur.wday >= WDAY_LAST) ? 3'd1 : cur.wday + 3'd1;
          nxt.mday = mday_w ? 5'd1 : cur.mday + 5'd1;
          if (mday_w) begin
            nxt.mon = mon_w ? 4'd1 : cur.mon + 4'd1;
            year_cy = mon_w;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cal_clock_top.sv
`timescale 1ns/1ps
module cal_clock_top
  import cal_pkg::*;
#(
  parameter int          YEAR_DIGITS = 4,
  parameter logic [31:0] RST_TIME    = 32'h0212_0000,
  parameter logic [15:0] RST_YEAR    = 16'h2000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     time_wr,
  input  logic [31:0]              time_wdata,
  input  logic                     year_wr,
  input  logic [4*YEAR_DIGITS-1:0] year_wdata,
  input  logic                     mtime_wr,
  input  logic [31:0]              mtime_wdata,
  input  logic                     myear_wr,
  input  logic [4*YEAR_DIGITS-1:0] myear_wdata,
  output logic [31:0]              time_q,
  output logic [4*YEAR_DIGITS-1:0] year_q,
  output logic                     alarm
);
  localparam int YW = 4 * YEAR_DIGITS;

  // reset synchronizer: assert async, release on clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  cal_time_t        time_r, time_n, adv_time, pend_t, pend_t_n, mtime_r, mtime_n;
  logic [YW-1:0]    year_r, year_n, year_inc, pend_y, pend_y_n, myear_r, myear_n;
  logic             pend_tv, pend_tv_n, pend_yv, pend_yv_n;
  logic             eq_d, eq_d_n, alarm_r, alarm_n, eq_now, year_cy;
  logic [4:0]       days;

  cal_month_len #(.YW(YW)) u_len (.mon(time_r.mon), .year(year_r), .days(days));
  cal_advance              u_adv (.cur(time_r), .days(days), .nxt(adv_time), .year_cy(year_cy));
  cal_bcd_inc #(.DIGITS(YEAR_DIGITS)) u_inc (.d(year_r), .q(year_inc));

  assign eq_now = (time_r == mtime_r) && (year_r == myear_r);

  always_comb begin
    time_n    = time_r;
    year_n    = year_r;
    if (tick) begin
      time_n = pend_tv ? pend_t : adv_time;
      if (pend_yv)                  year_n = pend_y;
      else if (!pend_tv && year_cy) year_n = year_inc;
    end
    pend_tv_n = time_wr | (pend_tv & ~tick);
    pend_yv_n = year_wr | (pend_yv & ~tick);
    pend_t_n  = time_wr ? cal_time_t'(time_wdata) : pend_t;
    pend_y_n  = year_wr ? year_wdata : pend_y;
    mtime_n   = mtime_wr ? cal_time_t'(mtime_wdata) : mtime_r;
    myear_n   = myear_wr ? myear_wdata : myear_r;
    eq_d_n    = eq_now;
    alarm_n   = eq_now & ~eq_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      time_r  <= cal_time_t'(RST_TIME);
      year_r  <= YW'(RST_YEAR);
      pend_tv <= 1'b0;
      pend_yv <= 1'b0;
      pend_t  <= '0;
      pend_y  <= '0;
      mtime_r <= '0;
      myear_r <= '0;
      eq_d    <= 1'b0;
      alarm_r <= 1'b0;
    end else begin
      time_r  <= time_n;
      year_r  <= year_n;
      pend_tv <= pend_tv_n;
      pend_yv <= pend_yv_n;
      pend_t  <= pend_t_n;
      pend_y  <= pend_y_n;
      mtime_r <= mtime_n;
      myear_r <= myear_n;
      eq_d    <= eq_d_n;
      alarm_r <= alarm_n;
    end
  end

  assign time_q = time_r;
  assign year_q = year_r;
  assign alarm  = alarm_r;
endmodule

// File: rtl/cal_clock_chk.sv
`timescale 1ns/1ps
module cal_clock_chk #(
  parameter int YW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [31:0]   time_q,
  input logic [YW-1:0] year_q,
  input logic [31:0]   mtime,
  input logic [YW-1:0] myear,
  input logic          pend_tv,
  input logic [31:0]   pend_t,
  input logic          alarm
);
  assert_time_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(time_q));

  assert_year_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(year_q));

  assert_sec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend_tv && time_q[5:0] < 6'd59) |=> (time_q[5:0] == $past(time_q[5:0]) + 6'd1));

  assert_load_install_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend_tv) |=> (time_q == $past(pend_t)));

  assert_alarm_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |-> $past(time_q == mtime && year_q == myear));

  assert_alarm_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> !alarm);
endmodule

bind cal_clock_top cal_clock_chk #(.YW(4*YEAR_DIGITS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tick(tick), .time_q(time_q), .year_q(year_q),
  .mtime(mtime_r), .myear(myear_r), .pend_tv(pend_tv), .pend_t(pend_t), .alarm(alarm)
);

// File: tb/tb_cal_clock_top.sv
`timescale 1ns/1ps
module tb_cal_clock_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        time_wr = 1'b0, year_wr = 1'b0, mtime_wr = 1'b0, myear_wr = 1'b0;
  logic [31:0] time_wdata = '0, mtime_wdata = '0;
  logic [15:0] year_wdata = '0, myear_wdata = '0;
  logic [31:0] time_q;
  logic [15:0] year_q;
  logic        alarm;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cal_clock_top dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .time_wr(time_wr), .time_wdata(time_wdata),
    .year_wr(year_wr), .year_wdata(year_wdata),
    .mtime_wr(mtime_wr), .mtime_wdata(mtime_wdata),
    .myear_wr(myear_wr), .myear_wdata(myear_wdata),
    .time_q(time_q), .year_q(year_q), .alarm(alarm)
  );

  // R2 layout
  function automatic logic [31:0] pk(int mon, int mday, int wday, int hr, int mi, int s);
    return {3'b0, 4'(mon), 5'(mday), 3'(wday), 5'(hr), 6'(mi), 6'(s)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic set_tm(logic [31:0] t, logic [15:0] y);
    @(negedge clk);
    time_wr = 1'b1; time_wdata = t; year_wr = 1'b1; year_wdata = y;
    @(negedge clk);
    time_wr = 1'b0; year_wr = 1'b0;
    do_tick();
  endtask

  task automatic step_and_check(string req, logic [31:0] t0, logic [15:0] y0,
                                logic [31:0] t1, logic [15:0] y1);
    set_tm(t0, y0);
    chk({req, " load"}, time_q, t0);
    do_tick();
    chk({req, " time"}, time_q, t1);
    chk({req, " year"}, {16'h0, year_q}, {16'h0, y1});
  endtask

  task automatic t_reset();
    chk("R1 time", time_q, 32'h0212_0000);
    chk("R1 year", {16'h0, year_q}, 32'h2000);
    chk("R1 alarm", {31'h0, alarm}, 32'h0);
  endtask

  task automatic t_seconds();
    set_tm(pk(1, 1, 1, 0, 0, 58), 16'h2023);
    repeat (3) @(negedge clk);
    chk("R3 idle hold", time_q, pk(1, 1, 1, 0, 0, 58));
    do_tick();
    chk("R3 sec+1", time_q, pk(1, 1, 1, 0, 0, 59));
    do_tick();
    chk("R3 min carry", time_q, pk(1, 1, 1, 0, 1, 0));
    chk("R2 field pos", time_q, 32'h0212_0040);
  endtask

  task automatic t_rollovers();
    step_and_check("R4 wday 7->1", pk(3, 31, 7, 23, 59, 59), 16'h2023, pk(4, 1, 1, 0, 0, 0), 16'h2023);
    step_and_check("R5 30-day", pk(4, 30, 3, 23, 59, 59), 16'h2023, pk(5, 1, 4, 0, 0, 0), 16'h2023);
    step_and_check("R5 31-day", pk(5, 30, 2, 23, 59, 59), 16'h2023, pk(5, 31, 3, 0, 0, 0), 16'h2023);
    step_and_check("R3 hour carry", pk(6, 10, 2, 13, 59, 59), 16'h2023, pk(6, 10, 2, 14, 0, 0), 16'h2023);
  endtask

  task automatic t_leap();
    step_and_check("R6 2023 feb28", pk(2, 28, 3, 23, 59, 59), 16'h2023, pk(3, 1, 4, 0, 0, 0), 16'h2023);
    step_and_check("R6 2024 feb28", pk(2, 28, 4, 23, 59, 59), 16'h2024, pk(2, 29, 5, 0, 0, 0), 16'h2024);
    step_and_check("R6 2024 feb29", pk(2, 29, 5, 23, 59, 59), 16'h2024, pk(3, 1, 6, 0, 0, 0), 16'h2024);
    step_and_check("R6 1900 feb28", pk(2, 28, 4, 23, 59, 59), 16'h1900, pk(3, 1, 5, 0, 0, 0), 16'h1900);
    step_and_check("R6 2000 feb28", pk(2, 28, 2, 23, 59, 59), 16'h2000, pk(2, 29, 3, 0, 0, 0), 16'h2000);
  endtask

  task automatic t_year();
    step_and_check("R7 2019", pk(12, 31, 3, 23, 59, 59), 16'h2019, pk(1, 1, 4, 0, 0, 0), 16'h2020);
    step_and_check("R7 2099", pk(12, 31, 5, 23, 59, 59), 16'h2099, pk(1, 1, 6, 0, 0, 0), 16'h2100);
    step_and_check("R7 9999", pk(12, 31, 6, 23, 59, 59), 16'h9999, pk(1, 1, 7, 0, 0, 0), 16'h0000);
  endtask

  task automatic t_load();
    logic [31:0] before_t;
    logic [15:0] before_y;
    before_t = time_q;
    before_y = year_q;
    @(negedge clk);
    time_wr = 1'b1; time_wdata = pk(7, 4, 2, 12, 30, 15);
    year_wr = 1'b1; year_wdata = 16'h2031;
    @(negedge clk);
    time_wr = 1'b0; year_wr = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 staged time", time_q, before_t);
    chk("R8 staged year", {16'h0, year_q}, {16'h0, before_y});
    do_tick();
    chk("R8 time applied", time_q, pk(7, 4, 2, 12, 30, 15));
    chk("R8 year applied", {16'h0, year_q}, 32'h2031);
  endtask

  task automatic t_alarm();
    set_tm(pk(8, 15, 4, 9, 0, 0), 16'h2030);
    @(negedge clk);
    mtime_wr = 1'b1; mtime_wdata = pk(8, 15, 4, 9, 0, 1);
    myear_wr = 1'b1; myear_wdata = 16'h2030;
    @(negedge clk);
    mtime_wr = 1'b0; myear_wr = 1'b0;
    chk("R9 no early alarm", {31'h0, alarm}, 32'h0);
    do_tick();
    chk("R9 match time", time_q, pk(8, 15, 4, 9, 0, 1));
    @(negedge clk);
    chk("R9 alarm pulse", {31'h0, alarm}, 32'h1);
    @(negedge clk);
    chk("R9 alarm one cycle", {31'h0, alarm}, 32'h0);
    // weekday mismatch only
    set_tm(pk(8, 15, 4, 9, 0, 5), 16'h2030);
    @(negedge clk);
    mtime_wr = 1'b1; mtime_wdata = pk(8, 15, 5, 9, 0, 6);
    @(negedge clk);
    mtime_wr = 1'b0;
    do_tick();
    chk("R10 time", time_q, pk(8, 15, 4, 9, 0, 6));
    @(negedge clk);
    chk("R10 no alarm", {31'h0, alarm}, 32'h0);
    @(negedge clk);
    chk("R10 no alarm later", {31'h0, alarm}, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_seconds();
    t_rollovers();
    t_leap();
    t_year();
    t_load();
    t_alarm();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule